// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block decides when a digitally controlled buck regulator may switch and what reference level its error loop should chase. A filtered power-good flag and an enable input must both be true before anything happens. The block then sweeps a reference code from zero up to full scale at a fixed pace. When the sweep ends it reports that the converter is running. The comparators, the supply monitor and the error amplifier sit outside the block and give it only digital flags.

An overcurrent flag (synchronized on entry) stops switching at once. It also starts a hiccup recovery that is timed in whole ramp periods. The ramp engine runs three times with the gates held off, and the fourth period is a real output ramp. If the fault is still present when switching resumes, the cycle starts again, with no limit. Dropping enable sends the block to its off state from any state and on the next clock. It also clears the ramp and any hiccup progress.

Top module: `ss_hiccup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `gate_off`=1, `run`=0 and `ref_code`=0.
- R2: No ramp starts unless both `en` and the filtered power-good are true. A `pwr_good` rise sampled at edge k sets the filter at edge k and starts the ramp at edge k+1, with `ref_code`=0 and `gate_off`=0. After that `ref_code` rises by one every STEP_DIV cycles.
- R3: The ramp state takes one cycle to observe full scale (all ones). `run` rises one cycle after `ref_code` first reads all ones. While running, `ref_code` stays at all ones and `gate_off` stays 0.
- R4: If `en` is low at an edge, the block is off after that edge (`gate_off`=1, `run`=0, `ref_code`=0). This beats any other condition, including an overcurrent seen in the same cycle. A later re-enable starts a fresh ramp from zero with no hiccup delay pending.
- R5: `oc_flag` passes through a two-flop synchronizer. If it is high at edge k while switching is allowed, then `gate_off`=1, `run`=0 and `ref_code`=0 after edge k+2.
- R6: After an overcurrent trip the gates stay off for three internal ramp periods of (2^CODE_W-1)*STEP_DIV+1 cycles each. Then a normal ramp from zero runs, and `run` follows it as in R3.
- R7: An overcurrent that is still present when the recovery ramp starts trips again and restarts the three-period delay, as often as it recurs. `oc_flag` has no effect while `gate_off` is 1.
- R8: If `pwr_good` is low for fewer than PG_FILT consecutive samples, there is no effect. If it is low for PG_FILT consecutive samples, the filtered flag clears at the last of them, and the block is off after the next edge.
- R9: If an overcurrent and ramp completion reach the controller in the same cycle, the overcurrent wins and the hiccup delay starts instead of `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Bias supply good flag from the supply monitor |
| en | input | 1 | Active-high enable |
| oc_flag | input | 1 | Overcurrent flag from the current comparator (asynchronous) |
| ref_code | output | CODE_W | Soft-start reference code to the error loop |
| run | output | 1 | High once the ramp has completed and the converter is regulating |
| gate_off | output | 1 | High when both gate drivers must be held low |

## Verification
Two pairs of functions can act in the same cycle. In the first, ramp completion and a synchronized overcurrent meet: the bench pulses `oc_flag` so that its synchronized copy reaches the controller on the exact edge where the ramp state sees full scale. It then expects the gates off and `run` low, not the run state. In the second, a one-cycle overcurrent pulse reaches the controller on the same edge at which `en` is sampled low. The outcome is judged one edge after enable returns: a fresh ramp with `gate_off`=0 shows the off path won, while a pending hiccup would keep the gates off.

// File: rtl/ssq_pkg.sv
// Package: shared types for the soft-start / hiccup sequencer.
// Assumes: nothing; pure type definitions.
package ssq_pkg;

    // Sequencer states: off, output ramp, regulating, silent delay ramp, recovery ramp
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RAMP  = 3'd1,
        ST_RUN   = 3'd2,
        ST_HDLY  = 3'd3,
        ST_HRAMP = 3'd4
    } seq_state_t;

endpackage

// File: rtl/ssq_sync.sv
// Module: ssq_sync
// Multi-stage flop synchronizer for a single asynchronous level.
// Assumes: STAGES >= 2; the input is a slowly changing level.
module ssq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // Shift the raw level through the synchronizing chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];

endmodule

// File: rtl/ssq_pg_filter.sv
// Module: ssq_pg_filter
// Gives the power-good flag a time hysteresis: it sets as soon as the input
// is seen high and clears only after PG_FILT consecutive low samples.
// Assumes: pwr_good is already synchronous to clk; PG_FILT >= 2.
module ssq_pg_filter #(
    parameter int PG_FILT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic pg_ok
);
    localparam int CNT_W = $clog2(PG_FILT) + 1;
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(PG_FILT - 1);

    logic [CNT_W-1:0] low_cnt;

    // Count consecutive low samples and drop the flag on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            pg_ok   <= 1'b0;
        end else if (pwr_good) begin
            low_cnt <= '0;
            pg_ok   <= 1'b1;
        end else if (low_cnt == LOW_LAST) begin
            pg_ok   <= 1'b0;
        end else begin
            low_cnt <= low_cnt + CNT_W'(1);
        end
    end

    AST_PG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_ok && pwr_good) |=> pg_ok); // R8

    AST_PG_SHORT_DIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_ok && !pwr_good && low_cnt < LOW_LAST) |=> pg_ok); // R8

endmodule

// File: rtl/ssq_ramp.sv
// Module: ssq_ramp
// Reference ramp engine: a prescaler sets the pace, and the code rises by one
// each STEP_DIV enabled cycles and saturates at all ones.
// Assumes: clr has priority over go; STEP_DIV >= 2.
module ssq_ramp #(
    parameter int CODE_W   = 8,
    parameter int STEP_DIV = 2539
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    output logic [CODE_W-1:0] code,
    output logic              full
);
    localparam int PS_W = $clog2(STEP_DIV);
    localparam logic [PS_W-1:0]   PS_LAST   = PS_W'(STEP_DIV - 1);
    localparam logic [CODE_W-1:0] CODE_FULL = '1;

    logic [PS_W-1:0] pscnt;

    // Prescale the clock into ramp steps
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       pscnt <= '0;
        else if (go)             pscnt <= (pscnt == PS_LAST) ? '0 : pscnt + PS_W'(1);
    end

    // Advance the code on each step until full scale
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            code <= '0;
        else if (go && pscnt == PS_LAST && code != CODE_FULL)
            code <= code + CODE_W'(1);
    end

    assign full = (code == CODE_FULL);

    AST_RAMP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !clr) |=> (code == $past(code) || code == $past(code) + CODE_W'(1))); // R2

    AST_RAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !clr) |=> $stable(code)); // R2

endmodule

// File: rtl/ssq_ctrl.sv
// Module: ssq_ctrl
// Sequencer state machine: start-up ramp, run, overcurrent shutdown and the
// hiccup delay that is counted in whole ramp periods.
// Assumes: oc_s and pg_ok are synchronous; ramp_full follows ramp_code.
module ssq_ctrl
    import ssq_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int HIC_PERIODS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pg_ok,
    input  logic              oc_s,
    input  logic [CODE_W-1:0] ramp_code,
    input  logic              ramp_full,
    output logic              ramp_clr,
    output logic              ramp_go,
    output logic [CODE_W-1:0] ref_code,
    output logic              run,
    output logic              gate_off
);
    localparam int DCNT_W = (HIC_PERIODS > 1) ? $clog2(HIC_PERIODS) : 1;
    localparam logic [DCNT_W-1:0] DCNT_LAST = DCNT_W'(HIC_PERIODS - 1);

    seq_state_t        state, state_n;
    logic [DCNT_W-1:0] dcnt, dcnt_n;
    logic              switching;

    assign switching = (state == ST_RAMP) || (state == ST_HRAMP) || (state == ST_RUN);

    // Next-state and ramp restart decision; off request has top priority
    always_comb begin
        state_n  = state;
        dcnt_n   = dcnt;
        ramp_clr = 1'b0;
        if (!en || !pg_ok) begin
            state_n  = ST_OFF;
            dcnt_n   = '0;
            ramp_clr = 1'b1;
        end else begin
            case (state)
                ST_OFF: begin
                    state_n  = ST_RAMP;
                    ramp_clr = 1'b1;
                end
                ST_RAMP, ST_HRAMP: begin
                    if (oc_s) begin
                        state_n  = ST_HDLY;
                        dcnt_n   = '0;
                        ramp_clr = 1'b1;
                    end else if (ramp_full) begin
                        state_n = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (oc_s) begin
                        state_n  = ST_HDLY;
                        dcnt_n   = '0;
                        ramp_clr = 1'b1;
                    end
                end
                ST_HDLY: begin
                    if (ramp_full) begin
                        ramp_clr = 1'b1;
                        if (dcnt == DCNT_LAST) state_n = ST_HRAMP;
                        else                   dcnt_n  = dcnt + DCNT_W'(1);
                    end
                end
                default: begin
                    state_n  = ST_OFF;
                    ramp_clr = 1'b1;
                end
            endcase
        end
    end

    // State and delay-period registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            dcnt  <= '0;
        end else begin
            state <= state_n;
            dcnt  <= dcnt_n;
        end
    end

    // Output decode: ramp code while ramping, full scale while running
    always_comb begin
        ramp_go  = (state == ST_RAMP) || (state == ST_HRAMP) || (state == ST_HDLY);
        run      = (state == ST_RUN);
        gate_off = !switching;
        case (state)
            ST_RAMP, ST_HRAMP: ref_code = ramp_code;
            ST_RUN:            ref_code = '1;
            default:           ref_code = '0;
        endcase
    end

    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_off && !run && ref_code == '0)); // R4

    AST_OC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_s && switching) |=> gate_off); // R5

    AST_RUN_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(ramp_full)); // R3

    AST_DCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= DCNT_LAST); // R6

    AST_HRAMP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HRAMP && $past(state) == ST_HDLY) |-> $past(dcnt) == DCNT_LAST); // R6

endmodule

// File: rtl/ss_hiccup_seq.sv
// Module: ss_hiccup_seq (top)
// Soft-start and hiccup fault sequencer for a digitally controlled buck stage.
// Assumes: pwr_good and en are synchronous to clk; oc_flag may be asynchronous.
module ss_hiccup_seq #(
    parameter int CODE_W      = 8,
    parameter int STEP_DIV    = 2539,
    parameter int PG_FILT     = 8,
    parameter int HIC_PERIODS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              en,
    input  logic              oc_flag,
    output logic [CODE_W-1:0] ref_code,
    output logic              run,
    output logic              gate_off
);
    logic              oc_s;
    logic              pg_ok;
    logic              ramp_clr, ramp_go, ramp_full;
    logic [CODE_W-1:0] ramp_code;

    ssq_sync #(.STAGES(SYNC_STAGES)) u_oc_sync (
        .clk(clk), .rst_n(rst_n), .d(oc_flag), .q(oc_s)
    );

    ssq_pg_filter #(.PG_FILT(PG_FILT)) u_pg (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pg_ok(pg_ok)
    );

    ssq_ramp #(.CODE_W(CODE_W), .STEP_DIV(STEP_DIV)) u_ramp (
        .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .go(ramp_go),
        .code(ramp_code), .full(ramp_full)
    );

    ssq_ctrl #(.CODE_W(CODE_W), .HIC_PERIODS(HIC_PERIODS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .pg_ok(pg_ok), .oc_s(oc_s),
        .ramp_code(ramp_code), .ramp_full(ramp_full),
        .ramp_clr(ramp_clr), .ramp_go(ramp_go),
        .ref_code(ref_code), .run(run), .gate_off(gate_off)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (gate_off && !run && ref_code == '0)); // R1

endmodule

// File: tb/ss_hiccup_seq_test.sv
// Scoreboard bench: the driver pushes timed expectations into a queue,
// and a monitor pops and compares them at the falling edge.
module ss_hiccup_seq_test;
    localparam int CW  = 4;
    localparam int SD  = 3;
    localparam int PF  = 4;
    localparam int PER = 15 * SD + 1;   // cycles per internal ramp period

    typedef struct {
        int          at;
        logic [CW-1:0] code;
        logic        run;
        logic        goff;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic en = 1'b0;
    logic oc_flag = 1'b0;
    logic [CW-1:0] ref_code;
    logic run, gate_off;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ss_hiccup_seq #(.CODE_W(CW), .STEP_DIV(SD), .PG_FILT(PF), .HIC_PERIODS(3), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .en(en), .oc_flag(oc_flag),
        .ref_code(ref_code), .run(run), .gate_off(gate_off)
    );

    // Driver side: insert an expectation in cycle order
    task automatic expect_at(int at, logic [CW-1:0] c, logic r, logic g, string tag);
        exp_t e;
        int   i;
        e.at = at; e.code = c; e.run = r; e.goff = g; e.tag = tag;
        i = 0;
        while (i < q.size() && q[i].at <= at) i++;
        q.insert(i, e);
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: compare due expectations against the outputs
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if (e.at != cyc || ref_code !== e.code || run !== e.run || gate_off !== e.goff) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got code=%0d run=%b goff=%b, expected code=%0d run=%b goff=%b",
                         e.tag, e.at, ref_code, run, gate_off, e.code, e.run, e.goff);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int k, s, e1, e2, e3;
        // R1: reset state
        repeat (3) @(negedge clk);
        k = cyc;
        expect_at(k + 1, 0, 0, 1, "R1 reset");
        wait_to(k + 1);
        rst_n = 1'b1;

        // R2: enable alone does not start; R7: oc ignored while off
        k = cyc;
        en = 1'b1;
        expect_at(k + 6, 0, 0, 1, "R7 oc while off");
        expect_at(k + 8, 0, 0, 1, "R2 no power good");
        wait_to(k + 2); oc_flag = 1'b1;
        wait_to(k + 3); oc_flag = 1'b0;
        wait_to(k + 10);

        // R2, R3: normal start-up ramp
        k = cyc;
        pwr_good = 1'b1;
        s = k + 2;
        expect_at(k + 1, 0, 0, 1, "R2 filter latency");
        expect_at(s, 0, 0, 0, "R2 ramp start");
        expect_at(s + SD, 1, 0, 0, "R2 first step");
        expect_at(s + 7 * SD, 7, 0, 0, "R2 mid ramp");
        expect_at(s + 15 * SD, 15, 0, 0, "R3 full not yet run");
        expect_at(s + PER, 15, 1, 0, "R3 run");
        wait_to(s + 50);

        // R8: short dip ignored
        k = cyc;
        expect_at(k + 6, 15, 1, 0, "R8 short dip");
        pwr_good = 1'b0;
        wait_to(k + 3); pwr_good = 1'b1;
        wait_to(k + 8);

        // R5, R6, R7: trip, delay, persistent fault retrip, recovery
        k = cyc;
        oc_flag = 1'b1;
        e1 = k + 3;
        expect_at(k + 2, 15, 1, 0, "R5 sync latency");
        expect_at(e1, 0, 0, 1, "R5 shutdown");
        expect_at(e1 + 60, 0, 0, 1, "R6 delay");
        expect_at(e1 + 3 * PER - 1, 0, 0, 1, "R6 delay end");
        expect_at(e1 + 3 * PER, 0, 0, 0, "R6 retry ramp");
        e2 = e1 + 3 * PER + 1;
        expect_at(e2, 0, 0, 1, "R7 retrip");
        expect_at(e2 + 3 * PER - 1, 0, 0, 1, "R7 second delay");
        expect_at(e2 + 3 * PER, 0, 0, 0, "R7 second retry");
        expect_at(e2 + 3 * PER + SD, 1, 0, 0, "R6 recovery step");
        expect_at(e2 + 4 * PER, 15, 1, 0, "R6 recovered run");
        wait_to(e2 + 50); oc_flag = 1'b0;
        wait_to(e2 + 4 * PER + 6);

        // R4 then R9: enable drop, restart, overcurrent meets ramp completion
        k = cyc;
        en = 1'b0;
        expect_at(k + 1, 0, 0, 1, "R4 disable");
        wait_to(k + 3); en = 1'b1;
        s = k + 4;
        expect_at(s, 0, 0, 0, "R4 fresh ramp");
        expect_at(s + 15 * SD, 15, 0, 0, "R9 ramp full");
        expect_at(s + PER, 0, 0, 1, "R9 oc wins");
        wait_to(s + 43); oc_flag = 1'b1;
        wait_to(s + 44); oc_flag = 1'b0;
        e3 = s + PER;

        // R4: disable during hiccup delay clears it
        wait_to(e3 + 20); en = 1'b0;
        expect_at(e3 + 21, 0, 0, 1, "R4 disable in delay");
        wait_to(e3 + 23); en = 1'b1;
        s = e3 + 24;
        expect_at(s, 0, 0, 0, "R4 no pending hiccup");
        expect_at(s + PER, 15, 1, 0, "R4 run after re-enable");
        wait_to(s + 50);

        // R8: long dip turns the block off, then restart
        k = cyc;
        pwr_good = 1'b0;
        expect_at(k + PF, 15, 1, 0, "R8 last low sample");
        expect_at(k + PF + 1, 0, 0, 1, "R8 off");
        wait_to(k + 8); pwr_good = 1'b1;
        expect_at(k + 10, 0, 0, 0, "R8 restart");
        expect_at(k + 10 + SD, 1, 0, 0, "R8 restart step");
        wait_to(k + 10 + 50);

        // R4 with R9-style collision: enable low and overcurrent together
        k = cyc;
        oc_flag = 1'b1;
        wait_to(k + 1); oc_flag = 1'b0;
        wait_to(k + 2); en = 1'b0;
        expect_at(k + 3, 0, 0, 1, "R4 off beats oc");
        wait_to(k + 3); en = 1'b1;
        expect_at(k + 4, 0, 0, 0, "R4 ramp not hiccup");
        expect_at(k + 4 + PER, 15, 1, 0, "R4 run after collision");
        wait_to(k + 4 + PER + 3);

        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule